// File: doc/BRIEF.md
# Relay-XOR Phase Detector with Averaged Output

This block measures the phase offset between two band-limited, roughly sinusoidal sample streams that share one sample strobe. Each stream is reduced to its sign by a relay stage; the two relay states are combined by exclusive-OR into a pulse that is high while the signs disagree. The number of fast clock cycles during which that pulse is high is counted over one full injection period. The count is turned into degrees by dividing by the period, and the result is smoothed by a first-order shift-based low-pass filter.

The block sits inside a loop-margin monitor. Two filtered loop signals feed it, together with the injection period expressed in system clock cycles. Sampling jitter at the zero crossings makes each raw reading noisy. The averaged value is therefore the figure to read, and the raw value stays visible next to it. Both values update together once per injection period.

Top module: `pd_phase_detect`

## Requirements
- R1: On a clock edge where `samp_stb` is 1, a channel's relay becomes 1 if its sample is greater than zero and becomes 0 if its sample is less than zero. Both relays are 0 after reset.
- R2: A sample of exactly zero taken with the strobe leaves that channel's relay unchanged.
- R3: While `samp_stb` is 0, neither relay changes, whatever the sample inputs carry.
- R4: The cycles on which the two relays differ are counted over consecutive measurement windows. Each window lasts the effective period in clock cycles. The period input is taken on the last cycle of a window and applies to the next window. In steady state, `phase_vld` pulses exactly once per window, one window length apart.
- R5: A period input below the minimum window of 14 cycles (twice the 4 fraction bits, plus 6) is treated as exactly that minimum.
- R6: `phase_raw` equals floor(high_count * 180 * 16 / period). It is an unsigned degree value with 4 fraction bits, so 16 codes equal one degree.
- R7: `phase_raw` never exceeds 2880 (180 degrees). Relays that disagree for the whole window give exactly 2880, and relays that always agree give 0.
- R8: On each update, `phase_avg` becomes old + ((raw - old) >>> 3). The difference is signed and the shift is arithmetic (rounds toward minus infinity).
- R9: `phase_raw` and `phase_avg` change only in the cycle where `phase_vld` is 1, and that strobe lasts one cycle.
- R10: During and right after reset, `phase_raw`, `phase_avg` and `phase_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the pulse width is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_x | input | 16 | First filtered sample, signed two's complement |
| samp_y | input | 16 | Second filtered sample, signed two's complement |
| samp_stb | input | 1 | Qualifies both samples for the relays |
| period_cyc | input | 16 | Injection period in clock cycles |
| phase_raw | output | 12 | Unfiltered phase, degrees x16 |
| phase_avg | output | 12 | Low-pass averaged phase, degrees x16 |
| phase_vld | output | 1 | One-cycle pulse when both phase outputs update |

## Verification
Square waves with a known cycle offset are held periodic with the window length. The disagreement count then does not depend on where a window happens to start, which separates a correct scale and floor rounding from an off-by-one in counting or division. Offsets of zero and of half a period pin the two ends of the range. Constant sign pairs in all four combinations separate the relay polarity from the exclusive-OR. A pattern whose half-waves end in runs of zero samples tells zero-hold from zero-as-negative, because the two readings differ by 45 degrees. Opposite-sign samples with the strobe low show whether the qualification works. A period below the minimum, read through the spacing of the strobes, exposes whether the clamp is applied.

// File: rtl/pd_pkg.sv
package pd_pkg;
    // Degrees spanned when the relays disagree for a whole period
    localparam int unsigned HALF_TURN_DEG = 180;
    // Integer bits needed to hold 0..180
    localparam int unsigned DEG_INT_W     = 8;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/pd_sign_relay.sv
// Sign relay: tracks the sign of one qualified sample stream.
// Assumes: samples are signed two's complement; a zero sample keeps the
// previous state so that noise sitting on the crossing does not chatter.
module pd_sign_relay #(
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [SAMP_W-1:0] smp,
    output logic                     rel
);
    // Update the relay only on strobed, non-zero samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel <= 1'b0;
        end else if (stb) begin
            if (smp > 0)
                rel <= 1'b1;
            else if (smp < 0)
                rel <= 1'b0;
        end
    end
endmodule

// File: rtl/pd_window.sv
// Measurement window: counts cycles with the disagreement pulse high over
// one period and hands the count and the window length to the divider.
// Assumes: period input may change at any time; it is taken on the last
// cycle of a window and clamped up to MIN_PER. The first window after
// reset is MIN_PER cycles long.
module pd_window #(
    parameter int PER_W   = 16,
    parameter int MIN_PER = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_in,
    input  logic             diff,
    output logic             win_done,
    output logic [PER_W-1:0] win_high,
    output logic [PER_W-1:0] win_per
);
    localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PER);

    logic [PER_W-1:0] per_next;
    logic [PER_W-1:0] per_cur;
    logic [PER_W-1:0] pos;
    logic [PER_W-1:0] hcnt;
    logic [PER_W-1:0] hsum;
    logic             last;

    // Clamp the requested period and form the running high count
    always_comb begin
        per_next = (period_in < MIN_P) ? MIN_P : period_in;
        last     = (pos == per_cur - 1'b1);
        hsum     = hcnt + {{(PER_W-1){1'b0}}, diff};
    end

    // Advance position, accumulate high time, close the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            per_cur  <= MIN_P;
            hcnt     <= '0;
            win_done <= 1'b0;
            win_high <= '0;
            win_per  <= MIN_P;
        end else begin
            win_done <= 1'b0;
            if (last) begin
                pos      <= '0;
                hcnt     <= '0;
                per_cur  <= per_next;
                win_done <= 1'b1;
                win_high <= hsum;
                win_per  <= per_cur;
            end else begin
                pos  <= pos + 1'b1;
                hcnt <= hsum;
            end
        end
    end
endmodule

// File: rtl/pd_deg_divider.sv
// Degree scaler: computes floor(high * 180 * 2^FRAC_W / per) one quotient
// bit per cycle, most significant first.
// Assumes: high <= per, so the quotient is below 2^PH_W; start never
// arrives while a division runs (guaranteed by the minimum window).
module pd_deg_divider
    import pd_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [PER_W-1:0]              high,
    input  logic [PER_W-1:0]              per,
    output logic [DEG_INT_W+FRAC_W-1:0]   res,
    output logic                          res_vld
);
    localparam int PH_W   = DEG_INT_W + FRAC_W;
    localparam int NUM_W  = PER_W + PH_W;
    localparam int STEP_W = $clog2(PH_W);

    div_state_e        st;
    logic [NUM_W-1:0]  num;
    logic [NUM_W-1:0]  rem;
    logic [NUM_W-1:0]  dsh;
    logic [PH_W-1:0]   q;
    logic [PH_W-1:0]   q_nxt;
    logic [STEP_W-1:0] step;
    logic              take;

    // Scaled numerator, trial subtraction and next quotient
    always_comb begin
        num   = (NUM_W'(high) * NUM_W'(HALF_TURN_DEG)) << FRAC_W;
        take  = (rem >= dsh);
        q_nxt = {q[PH_W-2:0], take};
    end

    // Restoring division sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= DIV_IDLE;
            rem     <= '0;
            dsh     <= '0;
            q       <= '0;
            step    <= '0;
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= 1'b0;
            case (st)
                DIV_IDLE: begin
                    if (start) begin
                        rem  <= num;
                        dsh  <= NUM_W'(per) << (PH_W - 1);
                        q    <= '0;
                        step <= STEP_W'(PH_W - 1);
                        st   <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    if (take)
                        rem <= rem - dsh;
                    dsh <= dsh >> 1;
                    q   <= q_nxt;
                    if (step == '0) begin
                        st      <= DIV_IDLE;
                        res     <= q_nxt;
                        res_vld <= 1'b1;
                    end else begin
                        step <= step - 1'b1;
                    end
                end
                default: st <= DIV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pd_avg_lpf.sv
// Averaging stage: first-order IIR y += (x - y) >>> SHIFT_K, loaded on ld.
// Assumes: x is unsigned; the output always lies between old y and x.
module pd_avg_lpf #(
    parameter int PH_W    = 12,
    parameter int SHIFT_K = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [PH_W-1:0] x,
    output logic [PH_W-1:0] y
);
    logic signed [PH_W+1:0] diff;
    logic signed [PH_W+1:0] step;
    logic signed [PH_W+1:0] nxt;

    // Signed error, arithmetic shift, next filter state
    always_comb begin
        diff = $signed({2'b00, x}) - $signed({2'b00, y});
        step = diff >>> SHIFT_K;
        nxt  = $signed({2'b00, y}) + step;
    end

    // Hold the filter state between loads
    always_ff @(posedge clk) begin
        if (!rst_n)
            y <= '0;
        else if (ld)
            y <= nxt[PH_W-1:0];
    end
endmodule

// File: rtl/pd_phase_detect.sv
// Top: two sign relays, disagreement window counter, degree scaler and
// averaging filter. Raw and averaged phase update together with a
// one-cycle valid strobe once per window.
// Assumes: both samples share samp_stb; period_cyc is in clk cycles.
module pd_phase_detect
    import pd_pkg::*;
#(
    parameter int  SAMP_W = 16,
    parameter int  PER_W  = 16,
    parameter int  FRAC_W = 4,
    parameter int  LPF_K  = 3,
    localparam int PH_W   = DEG_INT_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SAMP_W-1:0] samp_x,
    input  logic signed [SAMP_W-1:0] samp_y,
    input  logic                     samp_stb,
    input  logic [PER_W-1:0]         period_cyc,
    output logic [PH_W-1:0]          phase_raw,
    output logic [PH_W-1:0]          phase_avg,
    output logic                     phase_vld
);
    // Window must outlast the divider (PH_W steps plus hand-off)
    localparam int MIN_PER = PH_W + 2;
    localparam int N_CH    = 2;

    logic signed [SAMP_W-1:0] samp_arr [N_CH];
    logic [N_CH-1:0]          rel_state;
    logic                     diff;
    logic                     win_done;
    logic [PER_W-1:0]         win_high;
    logic [PER_W-1:0]         win_per;
    logic [PH_W-1:0]          res;
    logic                     res_vld;

    assign samp_arr[0] = samp_x;
    assign samp_arr[1] = samp_y;

    for (genvar g = 0; g < N_CH; g++) begin : g_relay
        pd_sign_relay #(.SAMP_W(SAMP_W)) u_relay (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (samp_stb),
            .smp   (samp_arr[g]),
            .rel   (rel_state[g])
        );
    end

    // Disagreement pulse between the two relays
    always_comb diff = ^rel_state;

    pd_window #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_in (period_cyc),
        .diff      (diff),
        .win_done  (win_done),
        .win_high  (win_high),
        .win_per   (win_per)
    );

    pd_deg_divider #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (win_done),
        .high    (win_high),
        .per     (win_per),
        .res     (res),
        .res_vld (res_vld)
    );

    pd_avg_lpf #(.PH_W(PH_W), .SHIFT_K(LPF_K)) u_lpf (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (res_vld),
        .x     (res),
        .y     (phase_avg)
    );

    // Register raw phase and strobe in step with the filter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_raw <= '0;
            phase_vld <= 1'b0;
        end else begin
            phase_vld <= res_vld;
            if (res_vld)
                phase_raw <= res;
        end
    end
endmodule

// File: rtl/pd_phase_detect_chk.sv
// Checker for pd_phase_detect: relay behaviour, output range, update
// discipline, filter bounds and strobe spacing.
module pd_phase_detect_chk #(
    parameter int SAMP_W  = 16,
    parameter int PH_W    = 12,
    parameter int FRAC_W  = 4,
    parameter int MIN_PER = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic signed [SAMP_W-1:0] samp_x,
    input logic                     samp_stb,
    input logic [1:0]               rel_state,
    input logic [PH_W-1:0]          phase_raw,
    input logic [PH_W-1:0]          phase_avg,
    input logic                     phase_vld
);
    localparam int          FULL_SCALE = 180 << FRAC_W;
    localparam int          GAP_W      = 16;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap;
    logic             seen;

    // Cycles since the last valid strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (phase_vld) begin
            gap  <= 16'd1;
            seen <= 1'b1;
        end else if (gap != GAP_MAX) begin
            gap <= gap + 1'b1;
        end
    end

    a_r1_relay_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && samp_x > 0) |=> rel_state[0]);
    a_r1_relay_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && samp_x < 0) |=> !rel_state[0]);
    a_r2_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && samp_x == 0) |=> $stable(rel_state[0]));
    a_r3_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_stb |=> $stable(rel_state));
    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |-> (int'(phase_raw) <= FULL_SCALE));
    a_r9_raw_only_on_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_raw) |-> phase_vld);
    a_r9_avg_only_on_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_avg) |-> phase_vld);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |=> !phase_vld);
    a_r8_avg_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |-> ((phase_avg >= $past(phase_avg) && phase_avg <= phase_raw) ||
                       (phase_avg <= $past(phase_avg) && phase_avg >= phase_raw)));
    a_r5_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && seen) |-> (int'(gap) >= MIN_PER));
endmodule

bind pd_phase_detect pd_phase_detect_chk #(
    .SAMP_W  (SAMP_W),
    .PH_W    (PH_W),
    .FRAC_W  (FRAC_W),
    .MIN_PER (MIN_PER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_x    (samp_x),
    .samp_stb  (samp_stb),
    .rel_state (rel_state),
    .phase_raw (phase_raw),
    .phase_avg (phase_avg),
    .phase_vld (phase_vld)
);

// File: tb/pd_phase_detect_test.sv
module pd_phase_detect_test;
    localparam int AMP     = 1000;
    localparam int FULL    = 2880;
    localparam int MIN_WIN = 14;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] samp_x = '0;
    logic signed [15:0] samp_y = '0;
    logic               samp_stb = 1'b0;
    logic [15:0]        period_cyc = 16'd64;
    logic [11:0]        phase_raw;
    logic [11:0]        phase_avg;
    logic               phase_vld;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int vld_cyc = 0;
    int prev_vld_cyc = 0;
    int m_avg = 0;
    int last_raw = 0;
    int last_avg = 0;
    bit finished = 1'b0;

    // Generator state: 0 square pair, 1 constants, 2 zero-run pattern
    int gmode = 1;
    int gp = 64;
    int gd = 0;
    int gcx = 0;
    int gcy = 0;
    bit gstb = 1'b0;

    always #2.5 clk = ~clk;

    pd_phase_detect uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_x     (samp_x),
        .samp_y     (samp_y),
        .samp_stb   (samp_stb),
        .period_cyc (period_cyc),
        .phase_raw  (phase_raw),
        .phase_avg  (phase_avg),
        .phase_vld  (phase_vld)
    );

    function automatic int sq(input int ph, input int p);
        return (ph < p / 2) ? AMP : -AMP;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Input generator, driven on falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            samp_stb = gstb;
            case (gmode)
                0: begin
                    samp_x = 16'(sq(cyc % gp, gp));
                    samp_y = 16'(sq((cyc + gp - gd) % gp, gp));
                end
                2: begin
                    samp_x = 16'(sq(cyc % gp, gp));
                    case (((cyc % gp) * 4) / gp)
                        0: samp_y = 16'(AMP);
                        2: samp_y = 16'(-AMP);
                        default: samp_y = 16'sd0;
                    endcase
                end
                default: begin
                    samp_x = 16'(gcx);
                    samp_y = 16'(gcy);
                end
            endcase
        end
    end

    // Output monitor: filter rule and hold-between-updates (R8, R9)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (phase_vld) begin
                    m_avg = m_avg + ((int'(phase_raw) - m_avg) >>> 3);
                    check(int'(phase_avg) == m_avg, "R8 avg update", int'(phase_avg), m_avg);
                end else begin
                    check(int'(phase_raw) == last_raw, "R9 raw hold", int'(phase_raw), last_raw);
                    check(int'(phase_avg) == last_avg, "R9 avg hold", int'(phase_avg), last_avg);
                end
                last_raw = int'(phase_raw);
                last_avg = int'(phase_avg);
            end
        end
    end

    task automatic wait_vld();
        do @(negedge clk); while (!phase_vld);
        prev_vld_cyc = vld_cyc;
        vld_cyc = cyc;
    endtask

    task automatic settle();
        repeat (3) wait_vld();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(phase_raw == '0, "R10 raw in reset", int'(phase_raw), 0);
        check(phase_avg == '0, "R10 avg in reset", int'(phase_avg), 0);
        check(phase_vld == 1'b0, "R10 vld in reset", int'(phase_vld), 0);
        rst_n = 1'b1;
        m_avg = 0; last_raw = 0; last_avg = 0;
        @(negedge clk);
        check(phase_raw == '0 && phase_avg == '0, "R10 after reset",
              int'(phase_raw) + int'(phase_avg), 0);
        check(phase_vld == 1'b0, "R10 vld after reset", int'(phase_vld), 0);
    endtask

    // R1: constant sign pairs through both relays
    task automatic t_relay(input int cx, input int cy, input int exp);
        gmode = 1; gcx = cx; gcy = cy; gstb = 1'b1;
        settle();
        check(int'(phase_raw) == exp, "R1 relay polarity", int'(phase_raw), exp);
    endtask

    // R4/R6/R7: square pair with offset d in a window of p cycles
    task automatic t_square(input int p, input int d);
        int exp;
        exp = (2 * d * FULL) / p;
        period_cyc = 16'(p); gp = p; gd = d; gmode = 0; gstb = 1'b1;
        settle();
        check(int'(phase_raw) == exp, "R6 scaled phase", int'(phase_raw), exp);
        check(vld_cyc - prev_vld_cyc == p, "R4 window spacing", vld_cyc - prev_vld_cyc, p);
    endtask

    // R2: zero runs must hold the relay, giving zero phase
    task automatic t_zero_hold();
        period_cyc = 16'd128; gp = 128; gmode = 2; gstb = 1'b1;
        settle();
        check(int'(phase_raw) == 0, "R2 zero sample holds relay", int'(phase_raw), 0);
    endtask

    // R3: opposite signs without strobe must not move the relays
    task automatic t_no_strobe();
        period_cyc = 16'd40;
        gmode = 1; gcx = AMP; gcy = AMP; gstb = 1'b1;
        settle();
        gcy = -AMP; gstb = 1'b0;
        settle();
        check(int'(phase_raw) == 0, "R3 unstrobed samples ignored", int'(phase_raw), 0);
        gstb = 1'b1;
        settle();
        check(int'(phase_raw) == FULL, "R3 strobe restored", int'(phase_raw), FULL);
    endtask

    // R5: period below the minimum window is raised to it
    task automatic t_clamp();
        period_cyc = 16'd3;
        gmode = 1; gcx = AMP; gcy = -AMP; gstb = 1'b1;
        settle();
        check(vld_cyc - prev_vld_cyc == MIN_WIN, "R5 clamped window",
              vld_cyc - prev_vld_cyc, MIN_WIN);
        check(int'(phase_raw) == FULL, "R7 full scale at minimum", int'(phase_raw), FULL);
    endtask

    initial begin
        t_reset();
        t_relay(AMP, -AMP, FULL);
        t_relay(-AMP, AMP, FULL);
        t_relay(AMP, AMP, 0);
        t_relay(-AMP, -AMP, 0);
        t_square(64, 8);
        t_square(100, 13);
        t_square(64, 0);
        t_square(64, 32);
        t_square(256, 37);
        t_zero_hold();
        t_no_strobe();
        t_clamp();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule